// File: doc/BRIEF.md
# Repeated Word Store Sequencer

This block fills a run of consecutive memory words with one 32-bit value. A single start pulse hands it a base address, a signed immediate offset, a count register and a data register. It computes the first address as base plus offset, then issues one write per word on a request/acknowledge port. The address grows by four after each accepted write.

Only the five low bits of the count register give the number of writes, so a run is 0 to 31 words long. A count of zero produces no write at all and only a completion pulse. All operands are captured on the start cycle. The block then runs on its own until it raises its one-cycle done pulse and returns to idle.

Top module: `wfill_seq`

## Requirements
- R1: After reset the block is idle: `wr_req_o`, `busy_o` and `done_o` are all low.
- R2: The first write of a run goes to address `base_i + offset_i` (modulo 2^32).
- R3: The number of writes equals `count_i[4:0]`; bits [31:5] of `count_i` have no effect on the run.
- R4: Every write of a run carries the same value on `wr_data_o`, equal to `data_i[31:0]` at start.
- R5: Each accepted write (request and acknowledge high at a rising edge) advances the next write address by exactly 4.
- R6: When `count_i[4:0]` is zero, no write request is made and `done_o` is high in the cycle after the start edge.
- R7: Once raised, `wr_req_o` stays high with a stable address and data until `wr_ack_i` is sampled high.
- R8: `done_o` is high for exactly one cycle, in the cycle after the edge that accepts the last write. The block is idle (`busy_o` low) in the cycle after that.
- R9: Operands are captured when start is accepted; later changes on `base_i`, `offset_i`, `count_i` and `data_i` do not alter the run.
- R10: A `start_i` pulse while `busy_o` is high is ignored.
- R11: The address computation wraps modulo 2^32, so a run that crosses the top of the address space continues at address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a run; accepted only when idle |
| base_i | input | 32 | Base address |
| offset_i | input | 32 | Signed immediate added to the base |
| count_i | input | 32 | Count register; low 5 bits give the word count |
| data_i | input | 32 | Value written to every word |
| wr_req_o | output | 1 | Write request, held until acknowledged |
| wr_addr_o | output | 32 | Write address |
| wr_data_o | output | 32 | Write data |
| wr_ack_i | input | 1 | Write acknowledge from memory |
| busy_o | output | 1 | High from the cycle after start until the run ends |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The table drives runs of 1, 3, 4, 5 and 31 words. These show whether counting stops at the right word and whether the upper count bits are masked: a count register of 0x...E4 must give four writes and 0x20 must give none. A negative offset checks the signed add. A base just below the top of the address space shows whether the address wraps. Acknowledge delays of 0 to 3 cycles separate a request that is held from one that drops or moves early. Starts issued mid-run, together with operands that are scrambled right after start, check that the captured operands and the ignore-while-busy rule hold.

// File: rtl/wfill_pkg.sv
package wfill_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_DONE  = 2'd2
    } wfill_state_e;
endpackage

// File: rtl/wfill_fsm.sv
module wfill_fsm
    import wfill_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic zero_cnt_i,
    input  logic ack_i,
    input  logic last_i,
    output logic load_o,
    output logic step_o,
    output logic req_o,
    output logic busy_o,
    output logic done_o
);
    typedef struct packed {
        wfill_state_e st;
        logic         req;
        logic         done;
    } fsm_t;

    fsm_t cur_q, nxt_d;

    always_comb begin
        nxt_d  = cur_q;
        load_o = 1'b0;
        step_o = 1'b0;
        case (cur_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    load_o   = 1'b1;
                    nxt_d.st = zero_cnt_i ? ST_DONE : ST_WRITE;
                end
            end
            ST_WRITE: begin
                if (ack_i) begin
                    step_o = 1'b1;
                    if (last_i) begin
                        nxt_d.st = ST_DONE;
                    end
                end
            end
            ST_DONE:  nxt_d.st = ST_IDLE;
            default:  nxt_d.st = ST_IDLE;
        endcase
        nxt_d.req  = (nxt_d.st == ST_WRITE);
        nxt_d.done = (nxt_d.st == ST_DONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, req: 1'b0, done: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign req_o  = cur_q.req;
    assign done_o = cur_q.done;
    assign busy_o = (cur_q.st != ST_IDLE);

    // R8: completion is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: zero-length run completes at once without a request
    p_zero_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && zero_cnt_i) |=> (done_o && !req_o));

    // R10: a start seen while busy does not reload operands
    p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !load_o);
endmodule

// File: rtl/wfill_counter.sv
module wfill_counter #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             step_i,
    output logic             zero_o,
    output logic             last_o
);
    typedef struct packed {
        logic [CNT_W-1:0] rem;
    } cnt_t;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load_i) begin
            nxt_d.rem = cnt_i;
        end else if (step_i) begin
            nxt_d.rem = cur_q.rem - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign zero_o = (cnt_i == '0);
    assign last_o = (cur_q.rem == ONE);

    // R3: the controller never accepts a write beyond the loaded count
    p_no_extra_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        step_i |-> (cur_q.rem != '0));
endmodule

// File: rtl/wfill_addr.sv
module wfill_addr #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] offset_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o
);
    localparam logic [ADDR_W-1:0] INC = ADDR_W'(STEP);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } ad_t;

    ad_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load_i) begin
            nxt_d.addr = base_i + offset_i;
            nxt_d.data = data_i;
        end else if (step_i) begin
            nxt_d.addr = cur_q.addr + INC;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign addr_o = cur_q.addr;
    assign data_o = cur_q.data;

    // R9: the captured value changes only when a run is loaded
    p_data_captured_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(data_o));
endmodule

// File: rtl/wfill_seq.sv
module wfill_seq #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int REG_W  = 32,
    parameter int CNT_W  = 5,
    parameter int STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] offset_i,
    input  logic [REG_W-1:0]  count_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              wr_req_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    input  logic              wr_ack_i,
    output logic              busy_o,
    output logic              done_o
);
    logic load_w, step_w, zero_w, last_w;

    wfill_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .zero_cnt_i (zero_w),
        .ack_i      (wr_ack_i),
        .last_i     (last_w),
        .load_o     (load_w),
        .step_o     (step_w),
        .req_o      (wr_req_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    wfill_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load_w),
        .cnt_i  (count_i[CNT_W-1:0]),
        .step_i (step_w),
        .zero_o (zero_w),
        .last_o (last_w)
    );

    wfill_addr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP(STEP)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load_w),
        .step_i   (step_w),
        .base_i   (base_i),
        .offset_i (offset_i),
        .data_i   (data_i),
        .addr_o   (wr_addr_o),
        .data_o   (wr_data_o)
    );

    // R7: an unacknowledged request holds with stable address and data
    p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && !wr_ack_i) |=> (wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o)));

    // R5: the next request after an accepted write is 4 bytes higher
    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && wr_ack_i) |=> (!wr_req_o || (wr_addr_o == $past(wr_addr_o) + ADDR_W'(STEP))));

    // R4: data does not change between writes of one run
    p_data_same_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && $past(wr_req_o)) |-> $stable(wr_data_o));

    // R6: no request coincides with completion
    p_no_req_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !wr_req_o);
endmodule

// File: tb/wfill_seq_tb.sv
module wfill_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] base_i = '0, offset_i = '0, count_i = '0, data_i = '0;
    logic        wr_ack_i = 1'b0;
    logic        wr_req_o, busy_o, done_o;
    logic [31:0] wr_addr_o, wr_data_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    wfill_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
        .offset_i(offset_i), .count_i(count_i), .data_i(data_i),
        .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
        .wr_ack_i(wr_ack_i), .busy_o(busy_o), .done_o(done_o)
    );

    // fields: base, offset, count, data, ack delay, poke start mid-run
    localparam int NV = 7;
    localparam logic [135:0] VEC [NV] = '{
        {32'h0000_1000, 32'h0000_0010, 32'h0000_0003, 32'hA5A5_A5A5, 4'd0, 4'd0},
        {32'h0000_2000, 32'hFFFF_FFF0, 32'hFFFF_FFE4, 32'h1234_5678, 4'd2, 4'd1},
        {32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'hDEAD_BEEF, 4'd0, 4'd0},
        {32'hFFFF_FFF8, 32'h0000_0000, 32'h0000_0005, 32'h0BAD_F00D, 4'd1, 4'd0},
        {32'h0000_4000, 32'h0000_0004, 32'h0000_0020, 32'h5555_AAAA, 4'd0, 4'd0},
        {32'h0000_8000, 32'h0000_0100, 32'h8000_001F, 32'hCAFE_0001, 4'd1, 4'd1},
        {32'h1000_0000, 32'h0000_0008, 32'h0000_0001, 32'h7777_0000, 4'd3, 4'd1}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_case(input logic [31:0] b, input logic [31:0] o, input logic [31:0] c,
                            input logic [31:0] d, input int dly, input bit poke);
        logic [31:0] exp_addr;
        int exp_n, n, w;
        bit seen_done;
        exp_addr = b + o;
        exp_n = int'(c[4:0]);
        n = 0; w = 0; seen_done = 1'b0;
        @(negedge clk);
        base_i = b; offset_i = o; count_i = c; data_i = d; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // R9: scramble operands right after capture
        base_i = ~b; offset_i = 32'h40; count_i = 32'h1F; data_i = ~d;
        for (int cyc = 0; cyc < 400; cyc++) begin
            if (cyc > 0) @(negedge clk);
            wr_ack_i = 1'b0;
            start_i  = 1'b0;
            if (done_o) begin
                seen_done = 1'b1;
                break;
            end
            if (wr_req_o) begin
                check(busy_o == 1'b1, "R10 busy during run", 32'(busy_o), 32'd1);
                if (w == dly) begin
                    check(wr_addr_o == exp_addr, "R2/R5/R11 address", wr_addr_o, exp_addr);
                    check(wr_data_o == d, "R4/R9 data", wr_data_o, d);
                    wr_ack_i = 1'b1;
                    n++;
                    exp_addr = exp_addr + 32'd4;
                    w = 0;
                end else begin
                    check(wr_addr_o == exp_addr, "R7 held address", wr_addr_o, exp_addr);
                    if (poke) start_i = 1'b1; // R10 start while busy
                    w++;
                end
            end
        end
        check(seen_done, "R8 done reached", 32'(seen_done), 32'd1);
        check(n == exp_n, "R3/R6 write count", 32'(n), 32'(exp_n));
        check(wr_req_o == 1'b0, "R6 no request at done", 32'(wr_req_o), 32'd0);
        @(negedge clk);
        check(done_o == 1'b0, "R8 single pulse", 32'(done_o), 32'd0);
        check(busy_o == 1'b0, "R8 idle after done", 32'(busy_o), 32'd0);
        check(wr_req_o == 1'b0, "R10 no late run", 32'(wr_req_o), 32'd0);
    endtask

    initial begin
        // R1 reset state
        #1;
        check(wr_req_o == 1'b0, "R1 req after reset", 32'(wr_req_o), 32'd0);
        check(busy_o == 1'b0, "R1 busy after reset", 32'(busy_o), 32'd0);
        check(done_o == 1'b0, "R1 done after reset", 32'(done_o), 32'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(busy_o == 1'b0 && done_o == 1'b0 && wr_req_o == 1'b0, "R1 idle without start",
              {29'd0, busy_o, done_o, wr_req_o}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            run_case(VEC[i][135:104], VEC[i][103:72], VEC[i][71:40], VEC[i][39:8],
                     int'(VEC[i][7:4]), VEC[i][0]);
        end

        // R6: zero count, done exactly one cycle after the start edge
        @(negedge clk);
        base_i = 32'h300; offset_i = 0; count_i = 32'hFFFF_FFC0; data_i = 32'h1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(done_o == 1'b1, "R6 done timing", 32'(done_o), 32'd1);
        check(wr_req_o == 1'b0, "R6 no write", 32'(wr_req_o), 32'd0);

        // R11: offset wraps the base
        run_case(32'hFFFF_FFFC, 32'h0000_0008, 32'd2, 32'h0F0F_0F0F, 0, 1'b0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule